// File: doc/BRIEF.md
# Pipelined Bus Memory Responder

This block is a memory target for a pipelined Wishbone bus. It holds a small word-addressed RAM and answers every request that a master presents while the bus cycle is open. Each request is taken as a read or a write. Writes merge the new data into the stored word one byte lane at a time, under the control of the byte-select bits. Reads return the addressed word. The acknowledge comes exactly one clock after the request, with the read data valid in that same cycle.

The responder never applies back-pressure, so a master can present one request on every clock and receive one acknowledge per clock, one cycle behind. The RAM is cleared by reset. The bus address counts 64-bit words. Address bits above the RAM depth are dropped, so the RAM repeats across the address space. The block is meant to sit behind a bus master in a test environment, as a zero-wait memory with a fixed latency.

Top module: `pipe_mem_responder`

## Requirements
- R1: `busStall` is 0 in every cycle, during reset and afterwards.
- R2: A request is accepted only at a rising clock edge where `busCyc` and `busStb` are both 1. A strobe seen while `busCyc` is 0 neither writes memory nor produces an acknowledge.
- R3: For each accepted request, `busAck` is 1 in the clock cycle that follows the accepting edge, provided `busCyc` is still 1. Back-to-back requests give back-to-back acknowledges.
- R4: `busAck` is never 1 unless a request was accepted at the previous rising edge. With `busCyc` high and `busStb` low, no acknowledge follows.
- R5: `busAck` is 0 whenever `busCyc` is 0, including a cycle in which the master drops `busCyc` right after a strobe.
- R6: On an accepted write (`busWe`=1), byte lane i (bits 8i+7 down to 8i) of the stored word takes `busWdat` when `busSel[i]` is 1 and keeps its old value when `busSel[i]` is 0. A write with `busSel`=0 leaves the word unchanged.
- R7: On an accepted read (`busWe`=0), `busRdat` carries the word stored at the address sampled with the strobe, in the same cycle as the matching `busAck`.
- R8: After reset, every word reads as zero until it is written.
- R9: Only the low log2(DEPTH) bits of `busAdr` select a word. Addresses that differ only in higher bits reach the same word.
- R10: A read accepted on the edge right after a write to the same word returns the newly written data.
- R11: `busRdat` changes only after an accepted read. It holds its value through write acknowledges and idle cycles, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low; clears the RAM and the response state |
| busCyc | input | 1 | Bus cycle open |
| busStb | input | 1 | Request strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busAdr | input | ADDR_W | Word address |
| busSel | input | 8 | Byte-lane enables for writes, bit i for byte lane i |
| busWdat | input | 64 | Write data |
| busRdat | output | 64 | Read data, valid with `busAck` after a read |
| busAck | output | 1 | Acknowledge, one clock after the request |
| busStall | output | 1 | Back-pressure, held at 0 |

## Verification
The bench builds the block with DEPTH=256 and ADDR_W=16. This leaves eight address bits above the index, so an address such as 259 reaches word 3 and the aliasing of R9 can be seen at the ports. The 256-word RAM is small enough for fresh, never-written words to check R8, and for a pipelined stream of mixed-lane writes and reads to run without gaps. That stream places a read right behind a write to the same word and compares each returned value with hand-worked expectations.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

  localparam int unsigned DATA_W = 64;
  localparam int unsigned LANES  = DATA_W / 8;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic wrEn;   // merge write data into the addressed word this edge
    logic rdEn;   // load the addressed word into the read register this edge
  } ctrl_strobes_t;

endpackage

// File: rtl/pmr_ctrl.sv
module pmr_ctrl
  import pmr_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          busCyc,
  input  logic          busStb,
  input  logic          busWe,
  output ctrl_strobes_t strobes,
  output logic          busAck
);

  logic acceptNow;
  logic pendingAck;

  // A request is taken only while the cycle is open; no stall ever applied
  assign acceptNow    = busCyc & busStb;
  assign strobes.wrEn = acceptNow & busWe;
  assign strobes.rdEn = acceptNow & ~busWe;

  // One-stage response pipeline: answers the strobe of the previous edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingAck <= 1'b0;
    end else if (!busCyc) begin
      pendingAck <= 1'b0;
    end else begin
      pendingAck <= acceptNow;
    end
  end

  // Once the cycle closes no acknowledge may remain visible
  assign busAck = pendingAck & busCyc;

endmodule

// File: rtl/pmr_datapath.sv
module pmr_datapath
  import pmr_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobes_t       strobes,
  input  logic [IDX_W-1:0]    wordIdx,
  input  logic [LANES-1:0]    laneSel,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData
);

  logic [DATA_W-1:0] memWords [DEPTH];
  logic [DATA_W-1:0] oldWord;
  logic [DATA_W-1:0] mergedWord;
  logic [DATA_W-1:0] rdReg;

  assign oldWord = memWords[wordIdx];

  // Per-lane choice between the new byte and the stored byte
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign mergedWord[8*lane +: 8] = laneSel[lane] ? wrData[8*lane +: 8]
                                                   : oldWord[8*lane +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < DEPTH; w++) begin
        memWords[w] <= '0;
      end
    end else if (strobes.wrEn) begin
      memWords[wordIdx] <= mergedWord;
    end
  end

  // Read register: changes only on an accepted read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdReg <= '0;
    end else if (strobes.rdEn) begin
      rdReg <= oldWord;
    end
  end

  assign rdData = rdReg;

endmodule

// File: rtl/pipe_mem_responder.sv
module pipe_mem_responder
  import pmr_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busCyc,
  input  logic              busStb,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAdr,
  input  logic [7:0]        busSel,
  input  logic [63:0]       busWdat,
  output logic [63:0]       busRdat,
  output logic              busAck,
  output logic              busStall
);

  localparam int unsigned IDX_W = $clog2(DEPTH);

  ctrl_strobes_t    strobes;
  logic [IDX_W-1:0] wordIdx;
  logic             unusedAdrHigh;

  // Upper address bits fold onto the RAM (aliasing)
  assign wordIdx       = busAdr[IDX_W-1:0];
  assign unusedAdrHigh = ^busAdr[ADDR_W-1:IDX_W];

  assign busStall = 1'b0;

  pmr_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busCyc  (busCyc),
    .busStb  (busStb),
    .busWe   (busWe),
    .strobes (strobes),
    .busAck  (busAck)
  );

  pmr_datapath #(
    .DEPTH (DEPTH)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wordIdx (wordIdx),
    .laneSel (busSel),
    .wrData  (busWdat),
    .rdData  (busRdat)
  );

endmodule

// File: rtl/pmr_checker.sv
module pmr_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busCyc,
  input logic        busStb,
  input logic        busWe,
  input logic [63:0] busRdat,
  input logic        busAck,
  input logic        busStall
);

  // R1: back-pressure is never applied
  a_r1_no_stall: assert property (@(posedge clk) busStall == 1'b0);

  // R3: an accepted request is answered on the next cycle if the bus stays open
  a_r3_ack_follows: assert property (@(posedge clk) disable iff (!rstN)
    (busCyc && busStb) |=> (busAck || !busCyc));

  // R4: no acknowledge without a request on the previous edge
  a_r4_no_spurious_ack: assert property (@(posedge clk) disable iff (!rstN)
    busAck |-> $past(busCyc && busStb));

  // R5: acknowledge never visible outside a bus cycle
  a_r5_ack_in_cycle: assert property (@(posedge clk) disable iff (!rstN)
    !busCyc |-> !busAck);

  // R11: read data only moves after an accepted read
  a_r11_rdat_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busCyc && busStb && !busWe) |-> $stable(busRdat));

endmodule

bind pipe_mem_responder pmr_checker i_pmr_checker (
  .clk      (clk),
  .rstN     (rstN),
  .busCyc   (busCyc),
  .busStb   (busStb),
  .busWe    (busWe),
  .busRdat  (busRdat),
  .busAck   (busAck),
  .busStall (busStall)
);

// File: tb/test_pipe_mem_responder.sv
module test_pipe_mem_responder;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 256;
  localparam int ADDR_W     = 16;
  localparam int NVEC       = 11;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busCyc = 1'b0;
  logic              busStb = 1'b0;
  logic              busWe = 1'b0;
  logic [ADDR_W-1:0] busAdr = '0;
  logic [7:0]        busSel = '0;
  logic [63:0]       busWdat = '0;
  logic [63:0]       busRdat;
  logic              busAck;
  logic              busStall;

  int total = 0;
  int bad   = 0;

  // Fields: we(1) | adr(16) | sel(8) | wdat(64) | expected read data(64)
  localparam logic [152:0] VECS [NVEC] = '{
    {1'b1, 16'd3,     8'hFF, 64'h1111_2222_3333_4444, 64'h0},
    {1'b1, 16'd5,     8'h0F, 64'hAAAA_BBBB_CCCC_DDDD, 64'h0},
    {1'b1, 16'd5,     8'hA0, 64'h1234_5678_9ABC_DEF0, 64'h0},
    {1'b0, 16'd5,     8'h00, 64'h0,                   64'h1200_5600_CCCC_DDDD},
    {1'b0, 16'd3,     8'h00, 64'h0,                   64'h1111_2222_3333_4444},
    {1'b0, 16'd9,     8'h00, 64'h0,                   64'h0},
    {1'b1, 16'd259,   8'h01, 64'h0000_0000_0000_00FF, 64'h0},
    {1'b0, 16'd3,     8'h00, 64'h0,                   64'h1111_2222_3333_44FF},
    {1'b1, 16'd7,     8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
    {1'b0, 16'd7,     8'h00, 64'h0,                   64'h0},
    {1'b0, 16'h0105,  8'h00, 64'h0,                   64'h1200_5600_CCCC_DDDD}
  };

  pipe_mem_responder #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
  ) i_pipe_mem_responder (
    .clk      (clk),
    .rstN     (rstN),
    .busCyc   (busCyc),
    .busStb   (busStb),
    .busWe    (busWe),
    .busAdr   (busAdr),
    .busSel   (busSel),
    .busWdat  (busWdat),
    .busRdat  (busRdat),
    .busAck   (busAck),
    .busStall (busStall)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic s, input logic w,
                       input logic [ADDR_W-1:0] a, input logic [7:0] sl,
                       input logic [63:0] d);
    busCyc  = c;
    busStb  = s;
    busWe   = w;
    busAdr  = a;
    busSel  = sl;
    busWdat = d;
  endtask

  task automatic driveVec(input int idx);
    drive(1'b1, 1'b1, VECS[idx][152], VECS[idx][151:136], VECS[idx][135:128],
          VECS[idx][127:64]);
  endtask

  // One isolated read; returns data seen with the acknowledge
  task automatic singleRead(input logic [ADDR_W-1:0] a, output logic [63:0] d,
                            output logic ackSeen);
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b0, a, 8'h00, 64'h0);
    @(negedge clk);
    ackSeen = busAck;
    d = busRdat;
    drive(1'b0, 1'b0, 1'b0, '0, 8'h00, 64'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] lastRd;
    logic [63:0] rd;
    logic        ackSeen;

    // Reset state: R1, R11, R5
    repeat (3) @(negedge clk);
    check("R1 stall in reset", {63'd0, busStall}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 rdat after reset", busRdat, 64'd0);
    check("R5 ack idle after reset", {63'd0, busAck}, 64'd0);

    // Pipelined stream: one request per clock, table-driven
    lastRd = 64'd0;
    driveVec(0);
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      check($sformatf("R3 ack vec %0d", i), {63'd0, busAck}, 64'd1);
      check($sformatf("R1 stall vec %0d", i), {63'd0, busStall}, 64'd0);
      if (VECS[i][152] == 1'b0) begin
        // R7 R6 R8 R9 R10 via expected column
        check($sformatf("R7 rdat vec %0d", i), busRdat, VECS[i][63:0]);
        lastRd = VECS[i][63:0];
      end else begin
        check($sformatf("R11 rdat hold vec %0d", i), busRdat, lastRd);
      end
      if (i < NVEC - 1) driveVec(i + 1);
      else drive(1'b1, 1'b0, 1'b0, '0, 8'h00, 64'h0);
    end

    // R4: cycle open, strobe low -> no acknowledge
    @(negedge clk);
    check("R4 no ack without strobe", {63'd0, busAck}, 64'd0);
    check("R11 rdat held idle", busRdat, lastRd);
    drive(1'b0, 1'b0, 1'b0, '0, 8'h00, 64'h0);

    // R2: strobe with cycle low is ignored (no ack, no write)
    @(negedge clk);
    drive(1'b0, 1'b1, 1'b1, 16'd9, 8'hFF, 64'hDEAD_BEEF_DEAD_BEEF);
    @(negedge clk);
    check("R2 no ack when cycle low", {63'd0, busAck}, 64'd0);
    drive(1'b0, 1'b0, 1'b0, '0, 8'h00, 64'h0);
    singleRead(16'd9, rd, ackSeen);
    check("R2 ignored write left word", rd, 64'd0);
    check("R3 single read ack", {63'd0, ackSeen}, 64'd1);

    // R8: a fresh word far from the others reads zero
    singleRead(16'd200, rd, ackSeen);
    check("R8 unwritten word", rd, 64'd0);

    // R5: master drops the cycle right after a strobe
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b0, 16'd3, 8'h00, 64'h0);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, '0, 8'h00, 64'h0);
    #1;
    check("R5 ack cleared when cycle drops", {63'd0, busAck}, 64'd0);
    @(negedge clk);
    check("R5 ack stays low", {63'd0, busAck}, 64'd0);

    // R6: single-lane write in the middle of a word
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b1, 16'd5, 8'h10, 64'h0000_00EE_0000_0000);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, '0, 8'h00, 64'h0);
    singleRead(16'd5, rd, ackSeen);
    check("R6 lane 4 merge", rd, 64'h1200_56EE_CCCC_DDDD);

    // R1 after all traffic
    check("R1 stall at end", {63'd0, busStall}, 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule